// File: doc/BRIEF.md
# Block Sequence Number Source

This block frames a continuous sample stream into fixed-length blocks. While it runs it raises a one-cycle start-of-block strobe every `BLK_LEN` clock cycles and presents a 64-bit block sequence number for the current block. The number counts up by one from block to block. A sync flag marks the first block of each sync interval. The length of that interval is configured in clock cycles.

A small register port configures the block:

- **Word 0** holds the run controls: a run-enable bit and a wait-for-pulse bit.
- **Word 1** holds the sync interval in clock cycles.
- **Words 2 and 3** hold the starting sequence number as low and high halves. A read of these words returns the live count.

The block can start in two ways. It can start on the clock after the control write. It can also be armed so that it starts on the next rising edge of an external once-per-second pulse. This lets several blocks on separate boards begin their numbering at the same instant.

Top module: `bsn_framer`

## Requirements
- R1: After reset, `blk_sop`, `blk_sync` and `blk_active` are low, `blk_bsn` is zero, and reads of words 0 and 1 return zero.
- R2: A write to word 2 (address 2'd2) only stages the low 32 bits. The 64-bit starting number becomes `{word 3 data, staged low}` only when word 3 (address 2'd3) is written. A start after a low-only write uses the previously committed value.
- R3: Writing word 0 (address 2'd0) with bit 0 = 1 and bit 1 = 0 while idle starts the source. The first `blk_sop` is high in the cycle that follows the write's clock edge.
- R4: The first block after a start carries the committed starting number on `blk_bsn`. Each later block carries the previous number plus one.
- R5: While running, consecutive `blk_sop` pulses are exactly `BLK_LEN` cycles apart.
- R6: `blk_sync` is high with `blk_sop` on the first block after a start. After that it is high on a block start when a sync-interval boundary has passed since the previous block start. With the interval N from word 1 (address 2'd1, 0 treated as 1), block k ≥ 1 is flagged exactly when floor(k·BLK_LEN/N) > floor((k−1)·BLK_LEN/N).
- R7: Writing word 0 with bits [1:0] = 2'b11 while idle arms the source without starting it. The first `blk_sop` follows in the cycle after the edge at which `pps_in` is first sampled high.
- R8: A `pps_in` rising edge has no effect while the source is neither armed nor running. While the source is running, a `pps_in` edge does not move the block timing.
- R9: Writing word 0 with bit 0 = 0 while running lets the current block finish. No further `blk_sop` follows, and `blk_active` goes low.
- R10: Register reads return data on `mm_rdata` one cycle after `mm_rd`. Word 0 returns {30'b0, bit 1, bit 0}. Word 1 returns the interval. Word 2 returns the low half of the live `blk_bsn` and latches its high half. Word 3 returns that latched high half, so the pair forms one coherent 64-bit value.
- R11: The sequence number carries across the 32-bit boundary; for example, 0x1_FFFFFFFF is followed by 0x2_00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | External once-per-second pulse |
| mm_wr | input | 1 | Register write strobe |
| mm_rd | input | 1 | Register read strobe |
| mm_addr | input | 2 | Register word address |
| mm_wdata | input | 32 | Register write data |
| mm_rdata | output | 32 | Register read data, valid one cycle after `mm_rd` |
| blk_sop | output | 1 | Start-of-block strobe |
| blk_sync | output | 1 | Sync-interval flag, only together with `blk_sop` |
| blk_active | output | 1 | High while blocks are being generated |
| blk_bsn | output | 64 | Sequence number of the current block |

## Verification
The source is started both by a direct control write and by an armed pulse edge.

- **Intervals.** Sync intervals are tried that equal the block length, are a multiple of it, are not a multiple of it, and are zero. This separates a correct boundary-crossing rule from one that only counts blocks.
- **Starting numbers.** These include a value whose low half is about to wrap, which exposes a missing carry. A low-only write proves that staging does not commit.
- **Pulse handling.** Stray pulses while idle, and pulses in the middle of a block while running, must leave both the start time and the block spacing untouched.
- **Random runs.** Seeded random runs mix starting numbers, intervals, block counts and start modes against a computed model of block numbers and sync positions.

// File: rtl/bsnf_pkg.sv
package bsnf_pkg;
  localparam int BSN_W  = 64;
  localparam int WORD_W = 32;

  typedef logic [BSN_W-1:0]  bsn_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_INTV   = 2'd1,
    A_BSN_LO = 2'd2,
    A_BSN_HI = 2'd3
  } reg_addr_e;

  // next sequence number
  function automatic bsn_t bsn_step(input bsn_t v);
    return v + bsn_t'(1);
  endfunction

  // last clock of a sync interval; lengths 0 and 1 wrap every clock
  function automatic logic intv_last(input word_t cnt, input word_t len);
    return (len <= word_t'(1)) ? 1'b1 : (cnt == len - word_t'(1));
  endfunction
endpackage

// File: rtl/bsnf_regs.sv
module bsnf_regs
  import bsnf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mm_wr,
  input  logic        mm_rd,
  input  logic [1:0]  mm_addr,
  input  word_t       mm_wdata,
  input  bsn_t        cur_bsn,
  output word_t       mm_rdata,
  output logic        wr_ctrl,
  output logic        cfg_en,
  output logic        cfg_pps,
  output word_t       cfg_intv,
  output bsn_t        init_bsn
);
  word_t lo_stage, hi_snap;
  reg_addr_e a;

  assign a       = reg_addr_e'(mm_addr);
  assign wr_ctrl = mm_wr && (a == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      cfg_pps  <= 1'b0;
      cfg_intv <= '0;
      init_bsn <= '0;
      lo_stage <= '0;
      hi_snap  <= '0;
      mm_rdata <= '0;
    end else begin
      if (mm_wr) begin
        case (a)
          A_CTRL:   begin cfg_en <= mm_wdata[0]; cfg_pps <= mm_wdata[1]; end
          A_INTV:   cfg_intv <= mm_wdata;
          A_BSN_LO: lo_stage <= mm_wdata;
          A_BSN_HI: init_bsn <= {mm_wdata, lo_stage};
          default:  ;
        endcase
      end
      if (mm_rd) begin
        case (a)
          A_CTRL:   mm_rdata <= {30'b0, cfg_pps, cfg_en};
          A_INTV:   mm_rdata <= cfg_intv;
          A_BSN_LO: begin
            mm_rdata <= cur_bsn[WORD_W-1:0];
            hi_snap  <= cur_bsn[BSN_W-1:WORD_W];
          end
          A_BSN_HI: mm_rdata <= hi_snap;
          default:  ;
        endcase
      end
    end
  end

  // R2: staging the low word leaves the committed value untouched
  a_r2_low_stages: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr && a == A_BSN_LO) |=> $stable(init_bsn));
endmodule

// File: rtl/bsnf_ctrl.sv
module bsnf_ctrl
  import bsnf_pkg::*;
#(
  parameter int BLK_LEN = 1024
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pps_in,
  input  logic  wr_ctrl,
  input  logic  cmd_en,
  input  logic  cmd_pps,
  input  logic  cfg_en,
  input  word_t cfg_intv,
  output logic  start_evt,
  output logic  blk_end,
  output logic  sop,
  output logic  sync,
  output logic  active
);
  localparam int CNT_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_LEN - 1);

  logic pps_d, armed_q, run_q, pend_q;
  logic [CNT_W-1:0] blk_cnt;
  word_t int_cnt;

  // named internal events
  logic pps_rise, go_now, go_pps, int_wrap;
  assign pps_rise  = pps_in & ~pps_d;
  assign go_now    = wr_ctrl & cmd_en & ~cmd_pps;
  assign go_pps    = armed_q & pps_rise & ~wr_ctrl;
  assign start_evt = ~run_q & (go_now | go_pps);
  assign blk_end   = run_q & (blk_cnt == LAST);
  assign sop       = run_q & (blk_cnt == '0);
  assign int_wrap  = run_q & intv_last(int_cnt, cfg_intv);
  assign sync      = sop & pend_q;
  assign active    = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pps_d   <= 1'b0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      blk_cnt <= '0;
      int_cnt <= '0;
    end else begin
      pps_d <= pps_in;
      if (wr_ctrl)        armed_q <= cmd_en & cmd_pps & ~run_q;
      else if (start_evt) armed_q <= 1'b0;

      if (start_evt)               run_q <= 1'b1;
      else if (blk_end && !cfg_en) run_q <= 1'b0;

      if (start_evt)  blk_cnt <= '0;
      else if (run_q) blk_cnt <= blk_end ? '0 : blk_cnt + 1'b1;

      if (start_evt)  int_cnt <= '0;
      else if (run_q) int_cnt <= int_wrap ? '0 : int_cnt + word_t'(1);

      if (start_evt)     pend_q <= 1'b1;
      else if (sop)      pend_q <= int_wrap;
      else if (int_wrap) pend_q <= 1'b1;
    end
  end

  // R7: an armed source is never running
  a_r7_armed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> !run_q);
  // R6: the first block after a start is flagged
  a_r6_first_sync: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (sop && sync));
  // R8: a pulse inside a running block does not start a new one
  a_r8_no_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pps_rise && !blk_end) |=> !sop);
  // R9: a disabled source halts at the block boundary
  a_r9_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !cfg_en) |=> !run_q);
endmodule

// File: rtl/bsnf_count.sv
module bsnf_count
  import bsnf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic blk_end,
  input  logic cfg_en,
  input  bsn_t init_bsn,
  output bsn_t cur_bsn
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 cur_bsn <= '0;
    else if (start_evt)         cur_bsn <= init_bsn;
    else if (blk_end && cfg_en) cur_bsn <= bsn_step(cur_bsn);
  end
endmodule

// File: rtl/bsn_framer.sv
module bsn_framer
  import bsnf_pkg::*;
#(
  parameter int BLK_LEN = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pps_in,
  input  logic        mm_wr,
  input  logic        mm_rd,
  input  logic [1:0]  mm_addr,
  input  logic [31:0] mm_wdata,
  output logic [31:0] mm_rdata,
  output logic        blk_sop,
  output logic        blk_sync,
  output logic        blk_active,
  output logic [63:0] blk_bsn
);
  logic  wr_ctrl, cfg_en, cfg_pps, start_evt, blk_end;
  word_t cfg_intv;
  bsn_t  init_bsn, cur_bsn;

  bsnf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_addr(mm_addr),
    .mm_wdata(mm_wdata), .cur_bsn(cur_bsn), .mm_rdata(mm_rdata),
    .wr_ctrl(wr_ctrl), .cfg_en(cfg_en), .cfg_pps(cfg_pps),
    .cfg_intv(cfg_intv), .init_bsn(init_bsn)
  );

  bsnf_ctrl #(.BLK_LEN(BLK_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .wr_ctrl(wr_ctrl),
    .cmd_en(mm_wdata[0]), .cmd_pps(mm_wdata[1]), .cfg_en(cfg_en),
    .cfg_intv(cfg_intv), .start_evt(start_evt), .blk_end(blk_end),
    .sop(blk_sop), .sync(blk_sync), .active(blk_active)
  );

  bsnf_count u_count (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .blk_end(blk_end),
    .cfg_en(cfg_en), .init_bsn(init_bsn), .cur_bsn(cur_bsn)
  );

  assign blk_bsn = cur_bsn;

  // R4: the first block carries the committed starting number
  a_r4_first_bsn: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (blk_bsn == $past(init_bsn)));
  // R4, R11: each continued block steps by one, carry included
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && cfg_en) |=> (blk_sop && blk_bsn == $past(blk_bsn) + 64'd1));
  // R3: a start always opens a block on the next cycle
  a_r3_start_sop: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (blk_active && blk_sop));
endmodule

// File: tb/test_bsn_framer.sv
module test_bsn_framer;
  localparam int L = 8;

  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         sop, sync, active;
  wire  [63:0] bsn;

  bsn_framer #(.BLK_LEN(L)) i_bsn_framer (
    .clk(clk), .rst_n(rst_n), .pps_in(pps), .mm_wr(wr), .mm_rd(rd),
    .mm_addr(addr), .mm_wdata(wdata), .mm_rdata(rdata), .blk_sop(sop),
    .blk_sync(sync), .blk_active(active), .blk_bsn(bsn)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6 model: boundary crossed between consecutive block starts
  function automatic logic exp_sync(input int idx, input int n);
    longint nn = (n < 1) ? 1 : longint'(n);
    if (idx == 0) return 1'b1;
    return ((longint'(idx) * L) / nn) > ((longint'(idx - 1) * L) / nn);
  endfunction

  // run description, written only by the main sequence
  int run_id = 0;
  logic [63:0] run_bsn = '0;
  int run_intv = 0;

  // block monitor
  int seen_id = 0, bidx = 0, sop_total = 0;
  longint last_sop = 0;
  always @(negedge clk) begin
    if (rst_n && sop) begin
      if (seen_id != run_id) begin
        seen_id = run_id;
        bidx = 0;
      end else begin
        chk("R5 block spacing", 64'(cyc - last_sop), 64'(L));
      end
      chk("R4 block number", bsn, run_bsn + 64'(bidx));
      chk("R6 sync flag", {63'b0, sync}, {63'b0, exp_sync(bidx, run_intv)});
      last_sop = cyc;
      bidx++;
      sop_total++;
    end
  end

  task automatic mm_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic mm_read(input logic [1:0] a, output logic [31:0] d, output logic [63:0] snap);
    @(negedge clk); rd = 1'b1; addr = a; snap = bsn;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_cfg(input logic [63:0] init, input int intv);
    mm_write(2'd2, init[31:0]);
    mm_write(2'd3, init[63:32]);
    mm_write(2'd1, 32'(intv));
  endtask

  task automatic start_now(input logic [63:0] expb, input int intv);
    run_id++; run_bsn = expb; run_intv = intv;
    mm_write(2'd0, 32'd1);
    chk("R3 first block next cycle", {63'b0, sop}, 64'd1);
  endtask

  task automatic start_pps(input logic [63:0] expb, input int intv, input int dly);
    run_id++; run_bsn = expb; run_intv = intv;
    mm_write(2'd0, 32'd3);
    repeat (dly) @(negedge clk);
    chk("R7 armed waits for pulse", {63'b0, active}, 64'd0);
    pps = 1'b1;
    @(negedge clk);
    chk("R7 start after pulse edge", {63'b0, sop}, 64'd1);
    repeat (2) @(negedge clk);
    pps = 1'b0;
  endtask

  task automatic stop_run();
    int n;
    @(negedge clk);
    while (!sop) @(negedge clk);
    repeat (2) @(negedge clk);
    mm_write(2'd0, 32'd0);
    n = sop_total;
    repeat (3 * L) @(negedge clk);
    chk("R9 no block after stop", 64'(sop_total - n), 64'd0);
    chk("R9 inactive after stop", {63'b0, active}, 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic [63:0] snap, s2;
    int n;
    void'($urandom(32'h5EED_0017));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sop after reset", {63'b0, sop}, 64'd0);
    chk("R1 sync after reset", {63'b0, sync}, 64'd0);
    chk("R1 active after reset", {63'b0, active}, 64'd0);
    chk("R1 bsn after reset", bsn, 64'd0);
    mm_read(2'd0, d, snap); chk("R1 word0 after reset", 64'(d), 64'd0);
    mm_read(2'd1, d, snap); chk("R1 word1 after reset", 64'(d), 64'd0);

    // R2: low-only write does not commit
    set_cfg(64'h11, 2 * L);
    mm_write(2'd2, 32'h99);
    start_now(64'h11, 2 * L);
    chk("R2 low-only write ignored", bsn, 64'h11);
    repeat (5 * L) @(negedge clk);
    mm_read(2'd0, d, snap); chk("R10 word0 readback", 64'(d), 64'd1);
    mm_read(2'd1, d, snap); chk("R10 word1 readback", 64'(d), 64'(2 * L));
    stop_run();

    // R2: high write commits staged low; R6 non-multiple interval
    mm_write(2'd3, 32'd0);
    mm_write(2'd1, 32'd12);
    start_now(64'h99, 12);
    chk("R2 high write commits", bsn, 64'h99);
    repeat (7 * L) @(negedge clk);
    stop_run();

    // R11 carry, interval 0
    set_cfg(64'h1_FFFF_FFFE, 0);
    start_now(64'h1_FFFF_FFFE, 0);
    repeat (2 * L) @(negedge clk);
    chk("R11 carry into high half", bsn, 64'h2_0000_0000);
    mm_read(2'd2, lo, snap);
    repeat (L + 3) @(negedge clk);
    mm_read(2'd3, hi, s2);
    chk("R10 coherent pair", {hi, lo}, snap);
    stop_run();

    // R8: stray pulse while idle and unarmed
    n = sop_total;
    pps = 1'b1; repeat (2) @(negedge clk); pps = 1'b0;
    repeat (3 * L) @(negedge clk);
    chk("R8 idle pulse ignored (blocks)", 64'(sop_total - n), 64'd0);
    chk("R8 idle pulse ignored (active)", {63'b0, active}, 64'd0);

    // R7 armed start, R8 mid-run pulse keeps timing
    set_cfg(64'h500, 3 * L);
    start_pps(64'h500, 3 * L, 5);
    repeat (L + 3) @(negedge clk);
    pps = 1'b1; repeat (2) @(negedge clk); pps = 1'b0;
    repeat (6 * L) @(negedge clk);
    stop_run();

    // random runs
    for (int i = 0; i < 8; i++) begin
      logic [63:0] ib;
      int iv, nb;
      ib = {$urandom, $urandom};
      iv = $urandom_range(1, 5 * L);
      nb = $urandom_range(2, 7);
      set_cfg(ib, iv);
      if ($urandom_range(0, 1) == 1) start_pps(ib, iv, $urandom_range(1, 10));
      else start_now(ib, iv);
      repeat (nb * L) @(negedge clk);
      stop_run();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule